// File: doc/BRIEF.md
# Self-Timed Byte EEPROM Access Controller

This block sits between a processor register bus and a 1024-byte nonvolatile data array. Software reaches the array only through a small set of byte registers: a control/status register, a key register with no storage, a data register and a split address pair. A read is started by setting a command bit and completes one cycle later, loading the addressed byte into the data register. A write is a self-timed erase-then-program cycle paced by an internal cycle counter. It is only accepted after write enable has been set and a two-byte key has been written. A sticky completion flag is raised at the end of the write.

The block has two resets. The power-on reset clears everything. The warm reset returns the block to idle, but it keeps the memory-select bits. If the warm reset lands in the middle of a write, it sets the error flag, so that software can trace the aborted access afterwards. The array itself is modelled as a synchronous byte memory and holds its contents through either reset.

Top module: `eeprom_byte_ctrl`

## Requirements
- R1: After power-on reset, every register reads 00h and `wr_done_irq_o` is 0.
- R2: The address is 10 bits wide. The address-low register (index 3) supplies bits 7:0. The address-high register (index 4) keeps only its two low bits, and its upper six bits read back as 0.
- R3: `bus_idx_i` selects the register: 0 control, 1 key, 2 data, 3 address low, 4 address high, 5 flag. The control register layout is: bit 7 program-memory select, bit 6 configuration select, bit 5 always 0, bit 4 row-erase enable (stored only), bit 3 error, bit 2 write enable, bit 1 write busy, bit 0 read busy.
- R4: Software can only set the command bits 1:0. Writing 0 to them leaves them unchanged.
- R5: Writing control bit 0 = 1, with bits 7 and 6 written as 0, makes bit 0 read 1 for exactly one cycle. After that cycle the data register holds the addressed byte.
- R6: A read request made while bit 7 or bit 6 is being written as 1 is dropped: bit 0 stays 0 and the data register is unchanged.
- R7: A write starts only when the control write with bit 1 = 1 is the first access after writing 55h and then AAh to the key register. Any other access in between cancels the key.
- R8: A write request with write enable at 0, or without a valid key, starts nothing and sets the error bit.
- R9: After a write starts, bit 1 reads 1 for exactly WR_CYCLES cycles. It clears on the same edge that stores the byte, sets the completion flag and clears the error bit.
- R10: The address and data are captured when the write starts. Register writes made during the write do not change which byte is stored or where it goes.
- R11: Flag register bit 0 (also driven on `wr_done_irq_o`) stays 1 until software writes the flag register with bit 0 = 0. Software cannot set it.
- R12: A warm reset during a write aborts it. The error bit is set, bits 7 and 6 are kept, and the target location reads FFh (erased but not programmed).
- R13: A read request made while a write is running is ignored: bit 0 stays 0 and the data register keeps its value.
- R14: The key register always reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, synchronous; clears all state |
| rst_n_i | input | 1 | Warm reset, active low, synchronous; keeps select bits and flags an aborted write |
| bus_sel_i | input | 1 | Register access strobe, one access per cycle it is high |
| bus_we_i | input | 1 | 1 = register write, 0 = register read |
| bus_idx_i | input | 3 | Register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the indexed register (combinational) |
| wr_done_irq_o | output | 1 | Sticky write-completion interrupt flag |

## Verification
The assertions assume that the bus issues at most one access per cycle. They also assume that both resets are sampled only at clock edges, so a warm reset is seen as a whole cycle with the busy state still visible. The bench drives every access for exactly one cycle from the falling edge, and it applies the warm reset as a full low cycle in the middle of a write. It checks only array locations it has written earlier, so uninitialised memory never reaches a comparison.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

   typedef enum logic [2:0] {
      REG_CTRL    = 3'd0,
      REG_KEY     = 3'd1,
      REG_DATA    = 3'd2,
      REG_ADDR_LO = 3'd3,
      REG_ADDR_HI = 3'd4,
      REG_FLAG    = 3'd5
   } reg_idx_e;

   localparam int CB_RD   = 0;
   localparam int CB_WR   = 1;
   localparam int CB_WREN = 2;
   localparam int CB_ERR  = 3;
   localparam int CB_FREE = 4;
   localparam int CB_CFG  = 6;
   localparam int CB_PGM  = 7;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;
   localparam logic [7:0] ERASED     = 8'hFF;

endpackage

// File: rtl/eeprom_unlock.sv
module eeprom_unlock
   import eeprom_pkg::*;
#(
   parameter bit UNLOCK_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       clr_i,
   input  logic       acc_i,
   input  logic       key_wr_i,
   input  logic [7:0] key_i,
   output logic       armed_o
);

   generate
      if (UNLOCK_EN) begin : g_seq
         typedef enum logic [1:0] {K_IDLE = 2'd0, K_HALF = 2'd1, K_ARMED = 2'd2} kst_e;
         kst_e st_q;

         always_ff @(posedge clk_i) begin
            if (clr_i) begin
               st_q <= K_IDLE;
            end else if (acc_i || st_q == K_ARMED) begin
               if (st_q == K_HALF && key_wr_i && key_i == KEY_SECOND)
                  st_q <= K_ARMED;
               else if (key_wr_i && key_i == KEY_FIRST)
                  st_q <= K_HALF;
               else
                  st_q <= K_IDLE;
            end
         end

         assign armed_o = (st_q == K_ARMED);

         // R7: only the three legal key states are ever reached
         assert_key_state_R7: assert property (@(posedge clk_i) disable iff (clr_i)
            st_q != 2'd3);
         // R7: the armed window lasts a single cycle
         assert_armed_once_R7: assert property (@(posedge clk_i) disable iff (clr_i)
            armed_o |=> !armed_o);
      end else begin : g_open
         logic unused_key;
         assign unused_key = ^{clk_i, clr_i, acc_i, key_wr_i, key_i};
         assign armed_o    = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
   parameter int WR_CYCLES = 100000
) (
   input  logic clk_i,
   input  logic clr_i,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   localparam int CNT_W = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(WR_CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);

   // checker: length of the current busy run
   logic [CNT_W:0] run_q;
   always_ff @(posedge clk_i) begin
      if (clr_i)       run_q <= '0;
      else if (busy_q) run_q <= run_q + 1'b1;
      else             run_q <= '0;
   end

   // R9: a write never outlasts its programmed duration
   assert_busy_len_R9: assert property (@(posedge clk_i) disable iff (clr_i)
      busy_q |-> (int'(run_q) < WR_CYCLES));
   // R9: completion ends the busy period
   assert_done_ends_R9: assert property (@(posedge clk_i) disable iff (clr_i)
      done_o |=> !busy_q);
   // R9: a new write is never launched on top of a running one
   assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (clr_i)
      start_i |-> !busy_q);

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      rdata_q <= mem_q[raddr_i];
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/eeprom_byte_ctrl.sv
module eeprom_byte_ctrl
   import eeprom_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int WR_CYCLES = 100000,
   parameter bit UNLOCK_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       por_n_i,
   input  logic       rst_n_i,
   input  logic       bus_sel_i,
   input  logic       bus_we_i,
   input  logic [2:0] bus_idx_i,
   input  logic [7:0] bus_wdata_i,
   output logic [7:0] bus_rdata_o,
   output logic       wr_done_irq_o
);

   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 12) begin : g_bad_addr_w
         $error("eeprom_byte_ctrl: ADDR_W must lie between 9 and 12");
      end
      if (WR_CYCLES < 2) begin : g_bad_wr_cycles
         $error("eeprom_byte_ctrl: WR_CYCLES must be at least 2");
      end
   endgenerate

   // control and data state
   logic              pgm_q, cfg_q, free_q, err_q, wren_q, rd_q, irq_q;
   logic [7:0]        data_q, alo_q;
   logic [HI_W-1:0]   ahi_q;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [7:0]        lat_data_q;

   // decode
   logic wr_acc, ctrl_wr, key_wr, data_wr, alo_wr, ahi_wr, flag_wr;
   assign wr_acc  = bus_sel_i && bus_we_i;
   assign ctrl_wr = wr_acc && (bus_idx_i == REG_CTRL);
   assign key_wr  = wr_acc && (bus_idx_i == REG_KEY);
   assign data_wr = wr_acc && (bus_idx_i == REG_DATA);
   assign alo_wr  = wr_acc && (bus_idx_i == REG_ADDR_LO);
   assign ahi_wr  = wr_acc && (bus_idx_i == REG_ADDR_HI);
   assign flag_wr = wr_acc && (bus_idx_i == REG_FLAG);

   logic clr;
   assign clr = !por_n_i || !rst_n_i;

   logic [ADDR_W-1:0] cur_addr;
   assign cur_addr = {ahi_q, alo_q};

   // key sequence
   logic armed;
   eeprom_unlock #(.UNLOCK_EN(UNLOCK_EN)) u_unlock (
      .clk_i   (clk_i),
      .clr_i   (clr),
      .acc_i   (bus_sel_i),
      .key_wr_i(key_wr),
      .key_i   (bus_wdata_i),
      .armed_o (armed)
   );

   // command evaluation
   logic busy, wr_done;
   logic wr_req, wr_start, wr_bad, new_pgm, new_cfg, rd_start;
   assign wr_req   = ctrl_wr && bus_wdata_i[CB_WR];
   assign wr_start = wr_req && !busy && armed && wren_q;
   assign wr_bad   = wr_req && !busy && !(armed && wren_q);
   assign new_pgm  = ctrl_wr ? bus_wdata_i[CB_PGM] : pgm_q;
   assign new_cfg  = ctrl_wr ? bus_wdata_i[CB_CFG] : cfg_q;
   assign rd_start = ctrl_wr && bus_wdata_i[CB_RD] && !new_pgm && !new_cfg
                     && !busy && !rd_q && !wr_start;

   eeprom_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk_i  (clk_i),
      .clr_i  (clr),
      .start_i(wr_start),
      .busy_o (busy),
      .done_o (wr_done)
   );

   // array: erase at start, program at completion
   logic              arr_we;
   logic [ADDR_W-1:0] arr_waddr;
   logic [7:0]        arr_wdata, arr_rdata;
   assign arr_we    = wr_start || wr_done;
   assign arr_waddr = wr_start ? cur_addr : lat_addr_q;
   assign arr_wdata = wr_start ? ERASED : lat_data_q;

   eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
      .clk_i  (clk_i),
      .we_i   (arr_we),
      .waddr_i(arr_waddr),
      .wdata_i(arr_wdata),
      .raddr_i(cur_addr),
      .rdata_o(arr_rdata)
   );

   always_ff @(posedge clk_i) begin
      if (!por_n_i) begin
         pgm_q      <= 1'b0;
         cfg_q      <= 1'b0;
         free_q     <= 1'b0;
         err_q      <= 1'b0;
         wren_q     <= 1'b0;
         rd_q       <= 1'b0;
         irq_q      <= 1'b0;
         data_q     <= '0;
         alo_q      <= '0;
         ahi_q      <= '0;
         lat_addr_q <= '0;
         lat_data_q <= '0;
      end else if (!rst_n_i) begin
         err_q  <= err_q | busy;
         free_q <= 1'b0;
         wren_q <= 1'b0;
         rd_q   <= 1'b0;
         irq_q  <= 1'b0;
         data_q <= '0;
         alo_q  <= '0;
         ahi_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            pgm_q  <= bus_wdata_i[CB_PGM];
            cfg_q  <= bus_wdata_i[CB_CFG];
            free_q <= bus_wdata_i[CB_FREE];
            wren_q <= bus_wdata_i[CB_WREN];
            err_q  <= bus_wdata_i[CB_ERR];
         end
         if (wr_bad)  err_q <= 1'b1;
         if (wr_done) begin
            err_q  <= 1'b0;
            free_q <= 1'b0;
         end

         if (rd_start)  rd_q <= 1'b1;
         else if (rd_q) rd_q <= 1'b0;

         if (rd_q)         data_q <= arr_rdata;
         else if (data_wr) data_q <= bus_wdata_i;

         if (alo_wr) alo_q <= bus_wdata_i;
         if (ahi_wr) ahi_q <= bus_wdata_i[HI_W-1:0];

         if (wr_start) begin
            lat_addr_q <= cur_addr;
            lat_data_q <= data_q;
         end

         if (wr_done)                          irq_q <= 1'b1;
         else if (flag_wr && !bus_wdata_i[0])  irq_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (bus_idx_i)
         REG_CTRL:    bus_rdata_o = {pgm_q, cfg_q, 1'b0, free_q, err_q, wren_q, busy, rd_q};
         REG_DATA:    bus_rdata_o = data_q;
         REG_ADDR_LO: bus_rdata_o = alo_q;
         REG_ADDR_HI: bus_rdata_o = {{(8-HI_W){1'b0}}, ahi_q};
         REG_FLAG:    bus_rdata_o = {7'd0, irq_q};
         default:     bus_rdata_o = 8'h00;
      endcase
   end

   assign wr_done_irq_o = irq_q;

   // R5: a read occupies exactly one cycle
   assert_rd_one_cycle_R5: assert property (@(posedge clk_i) disable iff (clr)
      rd_q |=> !rd_q);
   // R6: a read never runs against program or configuration space
   assert_rd_gated_R6: assert property (@(posedge clk_i) disable iff (clr)
      rd_q |-> (!pgm_q && !cfg_q));
   // R13: reads and writes never overlap
   assert_no_rd_in_wr_R13: assert property (@(posedge clk_i) disable iff (clr)
      rd_q |-> !busy);
   // R8: a write only begins with write enable set
   assert_wr_needs_wren_R8: assert property (@(posedge clk_i) disable iff (clr)
      $rose(busy) |-> $past(wren_q));
   // R12: a warm reset during a write leaves the error bit set
   assert_err_on_abort_R12: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!rst_n_i && busy) |=> err_q);
   // R11: completion flag is never dropped without a clearing write
   assert_irq_sticky_R11: assert property (@(posedge clk_i) disable iff (clr)
      (irq_q && !flag_wr) |=> irq_q);

endmodule

// File: tb/eeprom_byte_ctrl_tb_top.sv
module eeprom_byte_ctrl_tb_top;

   localparam int WRC = 16;

   localparam logic [1:0] OPW = 2'd0;  // register write
   localparam logic [1:0] OPR = 2'd1;  // register read with compare
   localparam logic [1:0] OPN = 2'd2;  // idle cycles

   localparam logic [2:0] I_CTRL = 3'd0;
   localparam logic [2:0] I_KEY  = 3'd1;
   localparam logic [2:0] I_DATA = 3'd2;
   localparam logic [2:0] I_LO   = 3'd3;
   localparam logic [2:0] I_HI   = 3'd4;
   localparam logic [2:0] I_FLAG = 3'd5;

   localparam int NSTEP = 48;
   // {op, index, value, requirement}
   localparam logic [16:0] STEPS [NSTEP] = '{
      {OPW, I_HI,   8'hFF, 4'd2},   // R2 upper bits dropped
      {OPR, I_HI,   8'h03, 4'd2},
      {OPW, I_LO,   8'h5A, 4'd2},
      {OPR, I_LO,   8'h5A, 4'd2},
      {OPW, I_CTRL, 8'hF4, 4'd3},   // R3 bit 5 reads 0
      {OPR, I_CTRL, 8'hD4, 4'd3},
      {OPR, I_KEY,  8'h00, 4'd14},  // R14
      {OPW, I_KEY,  8'h37, 4'd14},
      {OPR, I_KEY,  8'h00, 4'd14},
      {OPW, I_CTRL, 8'h04, 4'd3},
      {OPR, I_CTRL, 8'h04, 4'd3},
      {OPW, I_DATA, 8'h3C, 4'd7},   // R7 proper unlocked write
      {OPW, I_KEY,  8'h55, 4'd7},
      {OPW, I_KEY,  8'hAA, 4'd7},
      {OPW, I_CTRL, 8'h06, 4'd7},
      {OPR, I_CTRL, 8'h06, 4'd7},
      {OPN, 3'd0,   8'd20, 4'd9},
      {OPR, I_CTRL, 8'h04, 4'd9},   // R9 write finished
      {OPR, I_FLAG, 8'h01, 4'd11},  // R11
      {OPW, I_DATA, 8'h00, 4'd5},   // R5 read back
      {OPW, I_CTRL, 8'h05, 4'd5},
      {OPR, I_CTRL, 8'h05, 4'd5},
      {OPR, I_DATA, 8'h3C, 4'd5},
      {OPW, I_DATA, 8'h11, 4'd6},   // R6 program select blocks read
      {OPW, I_CTRL, 8'h85, 4'd6},
      {OPR, I_CTRL, 8'h84, 4'd6},
      {OPR, I_DATA, 8'h11, 4'd6},
      {OPW, I_CTRL, 8'h45, 4'd6},   // R6 config select blocks read
      {OPR, I_CTRL, 8'h44, 4'd6},
      {OPR, I_DATA, 8'h11, 4'd6},
      {OPW, I_CTRL, 8'h00, 4'd8},   // R8 write enable off
      {OPW, I_KEY,  8'h55, 4'd8},
      {OPW, I_KEY,  8'hAA, 4'd8},
      {OPW, I_CTRL, 8'h02, 4'd8},
      {OPR, I_CTRL, 8'h08, 4'd8},
      {OPR, I_FLAG, 8'h01, 4'd11},
      {OPW, I_CTRL, 8'h04, 4'd7},   // R7 key broken by a read access
      {OPW, I_KEY,  8'h55, 4'd7},
      {OPR, I_DATA, 8'h11, 4'd7},
      {OPW, I_KEY,  8'hAA, 4'd7},
      {OPW, I_CTRL, 8'h06, 4'd7},
      {OPR, I_CTRL, 8'h0C, 4'd7},
      {OPW, I_FLAG, 8'h01, 4'd11},  // R11 write of 1 keeps flag
      {OPR, I_FLAG, 8'h01, 4'd11},
      {OPW, I_FLAG, 8'h00, 4'd11},
      {OPR, I_FLAG, 8'h00, 4'd11},
      {OPW, I_FLAG, 8'h01, 4'd11},  // R11 cannot be set by software
      {OPR, I_FLAG, 8'h00, 4'd11}
   };

   logic       clk = 1'b0;
   logic       por_n, rst_n, sel, we;
   logic [2:0] idx;
   logic [7:0] wdata, rdata;
   logic       irq;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   eeprom_byte_ctrl #(.ADDR_W(10), .WR_CYCLES(WRC), .UNLOCK_EN(1'b1)) dut_i (
      .clk_i        (clk),
      .por_n_i      (por_n),
      .rst_n_i      (rst_n),
      .bus_sel_i    (sel),
      .bus_we_i     (we),
      .bus_idx_i    (idx),
      .bus_wdata_i  (wdata),
      .bus_rdata_o  (rdata),
      .wr_done_irq_o(irq)
   );

   initial forever #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 5000) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic bus_wr(input logic [2:0] i, input logic [7:0] v);
      sel = 1'b1; we = 1'b1; idx = i; wdata = v;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] i, input logic [7:0] exp, input string req);
      sel = 1'b1; we = 1'b0; idx = i;
      #1 chk(req, rdata, exp);
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic peek(input logic [2:0] i, input logic [7:0] exp, input string req);
      idx = i;
      #1 chk(req, rdata, exp);
   endtask

   initial begin
      por_n = 1'b0; rst_n = 1'b0; sel = 1'b0; we = 1'b0; idx = '0; wdata = '0;
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);

      // R1 power-on state
      peek(I_CTRL, 8'h00, "R1");
      peek(I_DATA, 8'h00, "R1");
      peek(I_LO,   8'h00, "R1");
      peek(I_HI,   8'h00, "R1");
      peek(I_FLAG, 8'h00, "R1");
      chk("R1", {7'd0, irq}, 8'h00);

      for (int i = 0; i < NSTEP; i++) begin
         logic [16:0] s;
         s = STEPS[i];
         case (s[16:15])
            OPW: bus_wr(s[14:12], s[11:4]);
            OPR: bus_rd(s[14:12], s[11:4], $sformatf("R%0d step %0d", s[3:0], i));
            default: repeat (int'(s[11:4])) @(negedge clk);
         endcase
      end

      // R9 R10 R4 R13: timed write with register traffic during it
      bus_wr(I_HI, 8'h00);
      bus_wr(I_LO, 8'h05);
      bus_wr(I_DATA, 8'hA5);
      bus_wr(I_CTRL, 8'h04);
      bus_wr(I_KEY, 8'h55);
      bus_wr(I_KEY, 8'hAA);
      bus_wr(I_CTRL, 8'h06);         // write starts here
      bus_wr(I_DATA, 8'h00);         // R10 late data change
      bus_wr(I_LO, 8'h06);           // R10 late address change
      bus_wr(I_CTRL, 8'h04);         // R4 writing 0 to busy bit
      peek(I_CTRL, 8'h06, "R4");
      bus_wr(I_CTRL, 8'h05);         // R13 read during write
      peek(I_CTRL, 8'h06, "R13");
      peek(I_DATA, 8'h00, "R13");
      repeat (WRC - 1 - 4) @(negedge clk);
      peek(I_CTRL, 8'h06, "R9");
      chk("R9", {7'd0, irq}, 8'h00);
      @(negedge clk);
      peek(I_CTRL, 8'h04, "R9");
      chk("R9", {7'd0, irq}, 8'h01);
      bus_wr(I_LO, 8'h05);
      bus_wr(I_CTRL, 8'h05);
      @(negedge clk);
      peek(I_DATA, 8'hA5, "R10");

      // R12: warm reset lands mid-write
      bus_wr(I_HI, 8'h02);
      bus_wr(I_LO, 8'hAB);
      bus_wr(I_DATA, 8'h77);
      bus_wr(I_CTRL, 8'h04);
      bus_wr(I_KEY, 8'h55);
      bus_wr(I_KEY, 8'hAA);
      bus_wr(I_CTRL, 8'h06);
      bus_wr(I_CTRL, 8'hC4);
      peek(I_CTRL, 8'hC6, "R12");
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      peek(I_CTRL, 8'hC8, "R12");
      chk("R12", {7'd0, irq}, 8'h00);
      peek(I_HI, 8'h00, "R12");
      bus_wr(I_HI, 8'h02);
      bus_wr(I_LO, 8'hAB);
      bus_wr(I_CTRL, 8'h01);
      @(negedge clk);
      peek(I_DATA, 8'hFF, "R12");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule